// File: doc/BRIEF.md
# Programmable-Format UART Receiver

This block turns the serial stream on one asynchronous receive line into bytes. The frame format is chosen at run time by a 6-bit format field, and the transmitter uses the same field. The field sets the character length (5 to 8 bits), whether a parity bit follows the data, how that parity is judged (odd, even, always 1 or always 0), and whether the stop period is short or long. The line is sampled on a 16x oversampling tick that the surrounding logic supplies.

The line first passes through a two-flop synchronizer. A high-to-low transition opens a candidate start bit, and the receiver checks it again half a bit later to reject glitches. After that, every bit is sampled once, at its centre. Each received character appears right-aligned on the byte output. A one-cycle valid strobe marks it, and the parity-error and framing-error flags pulse in the same cycle. When the long stop setting is selected, the receiver ignores the line for the extra stop time before it looks for the next start.

Top module: `fmt_uart_rx`

## Requirements
- R1: `line_fmt[1:0]` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. They are placed from `rx_data[0]` upward, and the unused upper bits are 0. `rx_data` changes only in a cycle where `rx_valid` is high.
- R2: Out of reset, `rx_valid`, `parity_err` and `frame_err` are low and `rx_data` is 0x00. `rx_valid` is high for exactly one clock per character, in the clock after the tick that samples the first stop bit. The two error flags are high only in that cycle.
- R3: With `line_fmt[3]`=1 and `line_fmt[5]`=0, the bit after the data is checked as parity. `line_fmt[4]`=0 means the data plus parity must hold an odd number of ones, and `line_fmt[4]`=1 means an even number. On a mismatch, `parity_err` is set with the character.
- R4: With `line_fmt[3]`=1 and `line_fmt[5]`=1, the parity bit must be 1 when `line_fmt[4]`=0 and 0 when `line_fmt[4]`=1. Any other value sets `parity_err`.
- R5: With `line_fmt[3]`=0, no parity slot exists. The stop bit is sampled directly after the last data bit, and `parity_err` stays low.
- R6: If the first stop bit is sampled as 0, `frame_err` is set and the character is still delivered with `rx_valid`.
- R7: A low pulse that has ended by the 8th tick after the start was detected is a false start. It produces no character, and the receiver returns to waiting.
- R8: With `line_fmt[2]`=0, start detection resumes right after the stop sample. With `line_fmt[2]`=1, the line is ignored for 16 further ticks after the stop sample, or 8 ticks for 5-bit characters. After that window, a new start needs a fresh falling edge.
- R9: A start is recognised only on a high-to-low change. A line that stays low after a frame produces no further character until it has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| line_fmt | input | 6 | Format field: length [1:0], long stop [2], parity enable [3], parity select [4], forced parity [5] |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Last received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| parity_err | output | 1 | Parity mismatch on the strobed character |
| frame_err | output | 1 | First stop bit sampled low on the strobed character |

## Verification
The bench sends every character length and checks that the upper bits are cleared. A receiver that counted the wrong number of data bits would shift the stop bit into the data and raise false framing errors. Correct and deliberately corrupted parity bits are sent in all four parity modes. This catches a swapped odd/even sense or a swapped forced mark/space polarity. The bench also sends short glitches, which a receiver without the mid-start recheck would take as characters. A line held low after a framing error must not start a stream of 0x00 characters. Finally, low pulses are placed inside and just after the long-stop window. These separate the 1-, 1.5- and 2-bit stop settings, and a receiver that ignored the stop setting or used the wrong window length would pick up an extra character.

// File: rtl/fmt_uart_rx_pkg.sv
package fmt_uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_HOLD   = 3'd5
    } rx_state_e;

    // Format field, MSB first so that a cast from the 6-bit field lines up
    typedef struct packed {
        logic       par_force;
        logic       par_sel;
        logic       par_en;
        logic       long_stop;
        logic [1:0] len_code;
    } rx_fmt_t;

    function automatic rx_fmt_t unpack_fmt(input logic [5:0] raw);
        return rx_fmt_t'(raw);
    endfunction

endpackage

// File: rtl/fmt_uart_rx_sync.sv
module fmt_uart_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fmt_uart_rx_parity.sv
module fmt_uart_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] bits_i,
    input  logic              sel_i,
    input  logic              force_i,
    output logic              exp_bit_o
);
    // bits_i arrives with unused upper bits at zero, so a full reduction is exact
    always_comb begin
        if (force_i)    exp_bit_o = ~sel_i;
        else if (sel_i) exp_bit_o = ^bits_i;
        else            exp_bit_o = ~(^bits_i);
    end
endmodule

// File: rtl/fmt_uart_rx.sv
module fmt_uart_rx
    import fmt_uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [5:0]        line_fmt,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              frame_err
);
    localparam int CNT_W   = $clog2(OVERSAMPLE);
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int MIN_LEN = DATA_W - 3;

    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_CNT  = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVERSAMPLE / 2 - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par_bad;
        logic              armed;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              perr;
        logic              ferr;
    } rx_regs_t;

    rx_regs_t  r_d, r_q;
    rx_fmt_t   fmt;
    logic      rx_s;
    logic      exp_par;
    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] hold_last;

    fmt_uart_rx_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(rx_line),
        .sync_o (rx_s)
    );

    fmt_uart_rx_parity #(
        .DATA_W(DATA_W)
    ) u_parity (
        .bits_i   (r_q.shreg),
        .sel_i    (fmt.par_sel),
        .force_i  (fmt.par_force),
        .exp_bit_o(exp_par)
    );

    always_comb begin
        fmt       = unpack_fmt(line_fmt);
        last_idx  = IDX_W'(MIN_LEN - 1) + IDX_W'(fmt.len_code);
        hold_last = (fmt.len_code == 2'b00) ? HALF_CNT : BIT_CNT;
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.perr  = 1'b0;
        r_d.ferr  = 1'b0;
        if (baud_tick) begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (r_q.armed && !rx_s) begin
                        r_d.state = ST_START;
                        r_d.cnt   = '0;
                    end
                    r_d.armed = rx_s;
                end
                ST_START: begin
                    if (r_q.cnt == MID_CNT) begin
                        if (rx_s) begin
                            r_d.state = ST_IDLE;
                            r_d.armed = 1'b1;
                        end else begin
                            r_d.state   = ST_DATA;
                            r_d.cnt     = '0;
                            r_d.idx     = '0;
                            r_d.shreg   = '0;
                            r_d.par_bad = 1'b0;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (r_q.cnt == BIT_CNT) begin
                        r_d.cnt = '0;
                        r_d.shreg[r_q.idx] = rx_s;
                        if (r_q.idx == last_idx)
                            r_d.state = fmt.par_en ? ST_PARITY : ST_STOP;
                        else
                            r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (r_q.cnt == BIT_CNT) begin
                        r_d.cnt     = '0;
                        r_d.par_bad = (rx_s != exp_par);
                        r_d.state   = ST_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (r_q.cnt == BIT_CNT) begin
                        r_d.cnt   = '0;
                        r_d.valid = 1'b1;
                        r_d.data  = r_q.shreg;
                        r_d.perr  = r_q.par_bad;
                        r_d.ferr  = !rx_s;
                        if (fmt.long_stop) begin
                            r_d.state = ST_HOLD;
                        end else begin
                            r_d.state = ST_IDLE;
                            r_d.armed = rx_s;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (r_q.cnt == hold_last) begin
                        r_d.state = ST_IDLE;
                        r_d.armed = 1'b0;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.armed = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data    = r_q.data;
    assign rx_valid   = r_q.valid;
    assign parity_err = r_q.perr;
    assign frame_err  = r_q.ferr;
endmodule

// File: rtl/fmt_uart_rx_chk.sv
module fmt_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic [5:0]        line_fmt,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              parity_err,
    input logic              frame_err
);
    localparam int MIN_LEN = DATA_W - 3;

    logic [DATA_W-1:0] keep_mask;
    always_comb begin
        keep_mask = (DATA_W'(1) << (MIN_LEN + int'(line_fmt[1:0]))) - DATA_W'(1);
    end

    p_upper_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data & ~keep_mask) == '0));

    p_data_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_valid_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(baud_tick));

    p_flags_with_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err || frame_err) |-> rx_valid);

    p_no_parity_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !line_fmt[3]) |-> !parity_err);
endmodule

bind fmt_uart_rx fmt_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .line_fmt  (line_fmt),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .parity_err(parity_err),
    .frame_err (frame_err)
);

// File: tb/fmt_uart_rx_tb.sv
module fmt_uart_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic [5:0] fmt = 6'b000011;
    logic [7:0] rdata;
    logic       rvalid, perr, ferr;
    logic [1:0] div = 2'd0;

    int n_tests = 0;
    int n_fail  = 0;
    int vcnt    = 0;
    logic [7:0] last_data = 8'h00;
    logic       last_perr = 1'b0;
    logic       last_ferr = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        div  <= div + 2'd1;
        tick <= (div == 2'd3);
    end

    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            vcnt      <= vcnt + 1;
            last_data <= rdata;
            last_perr <= perr;
            last_ferr <= ferr;
        end
    end

    fmt_uart_rx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (tick),
        .line_fmt  (fmt),
        .rx_line   (rx),
        .rx_data   (rdata),
        .rx_valid  (rvalid),
        .parity_err(perr),
        .frame_err (ferr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (tick !== 1'b1);
        end
        @(negedge clk);
    endtask

    function automatic int len_of(input logic [5:0] f);
        return 5 + int'(f[1:0]);
    endfunction

    function automatic logic [7:0] masked(input logic [5:0] f, input logic [7:0] d);
        logic [7:0] m;
        m = 8'((16'd1 << len_of(f)) - 16'd1);
        return d & m;
    endfunction

    function automatic logic ref_par(input logic [5:0] f, input logic [7:0] d);
        logic ones;
        if (f[5]) return ~f[4];
        ones = ^masked(f, d);
        return f[4] ? ones : ~ones;
    endfunction

    function automatic int stop_len(input logic [5:0] f);
        if (!f[2]) return 16;
        return (f[1:0] == 2'b00) ? 24 : 32;
    endfunction

    task automatic send_frame(input logic [5:0] f, input logic [7:0] d, input logic flip,
                              input logic stop_v, input int stop_ticks);
        fmt = f;
        rx  = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < len_of(f); i++) begin
            rx = d[i];
            wait_ticks(16);
        end
        if (f[3]) begin
            rx = ref_par(f, d) ^ flip;
            wait_ticks(16);
        end
        rx = stop_v;
        wait_ticks(stop_ticks);
        rx = 1'b1;
    endtask

    task automatic frame_ok(input string req, input logic [5:0] f, input logic [7:0] d,
                            input logic flip, input logic exp_perr);
        int c0;
        c0 = vcnt;
        send_frame(f, d, flip, 1'b1, stop_len(f));
        wait_ticks(4);
        check(req, "char count", vcnt, c0 + 1);
        check(req, "data", int'(last_data), int'(masked(f, d)));
        check(req, "parity flag", int'(last_perr), int'(exp_perr));
        check(req, "framing flag", int'(last_ferr), 0);
    endtask

    task automatic t_reset();
        check("R2", "reset valid", int'(rvalid), 0);
        check("R2", "reset data", int'(rdata), 0);
        check("R2", "reset flags", int'({perr, ferr}), 0);
    endtask

    task automatic t_lengths();
        frame_ok("R1 len5", 6'b000000, 8'hB6, 1'b0, 1'b0);
        frame_ok("R1 len6", 6'b000001, 8'hE9, 1'b0, 1'b0);
        frame_ok("R1 len7", 6'b000010, 8'hD5, 1'b0, 1'b0);
        frame_ok("R1 len8", 6'b000011, 8'hA7, 1'b0, 1'b0);
        frame_ok("R5 no parity", 6'b000011, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_odd_even();
        frame_ok("R3 odd ok", 6'b001011, 8'h35, 1'b0, 1'b0);
        frame_ok("R3 odd bad", 6'b001011, 8'h35, 1'b1, 1'b1);
        frame_ok("R3 even ok", 6'b011010, 8'h6C, 1'b0, 1'b0);
        frame_ok("R3 even bad", 6'b011010, 8'h6C, 1'b1, 1'b1);
        frame_ok("R3 odd 5bit", 6'b001000, 8'hFF, 1'b0, 1'b0);
    endtask

    task automatic t_forced();
        frame_ok("R4 mark ok", 6'b101010, 8'h11, 1'b0, 1'b0);
        frame_ok("R4 mark bad", 6'b101010, 8'h11, 1'b1, 1'b1);
        frame_ok("R4 space ok", 6'b111001, 8'h2A, 1'b0, 1'b0);
        frame_ok("R4 space bad", 6'b111001, 8'h2A, 1'b1, 1'b1);
    endtask

    task automatic t_framing();
        int c0;
        c0 = vcnt;
        send_frame(6'b000011, 8'h5A, 1'b0, 1'b0, 48);
        rx = 1'b1;
        wait_ticks(40);
        check("R6", "char count", vcnt, c0 + 1);
        check("R6", "framing flag", int'(last_ferr), 1);
        check("R6", "data", int'(last_data), 8'h5A);
        check("R9", "no retrigger on held low", vcnt, c0 + 1);
        frame_ok("R9 recovery", 6'b000011, 8'hC3, 1'b0, 1'b0);
    endtask

    task automatic t_false_start();
        int c0;
        c0 = vcnt;
        rx = 1'b0;
        wait_ticks(5);
        rx = 1'b1;
        wait_ticks(200);
        check("R7", "glitch ignored", vcnt, c0);
        frame_ok("R7 recovery", 6'b000011, 8'h81, 1'b0, 1'b0);
    endtask

    task automatic t_hold(input string req, input logic [5:0] f, input int stop_hi,
                          input int extra, input logic [7:0] extra_data);
        int c0;
        c0 = vcnt;
        send_frame(f, 8'h12, 1'b0, 1'b1, stop_hi);
        rx = 1'b0;
        wait_ticks(10);
        rx = 1'b1;
        wait_ticks(250);
        check(req, "char count", vcnt, c0 + 1 + extra);
        if (extra != 0) check(req, "extra char", int'(last_data), int'(extra_data));
        else            check(req, "frame data", int'(last_data), int'(masked(f, 8'h12)));
    endtask

    task automatic t_stop_lengths();
        frame_ok("R8 two stop", 6'b000111, 8'h3E, 1'b0, 1'b0);
        frame_ok("R8 one and half stop", 6'b000100, 8'h0D, 1'b0, 1'b0);
        t_hold("R8 short stop sees edge", 6'b000011, 12, 1, 8'hFF);
        t_hold("R8 long stop masks edge", 6'b000111, 12, 0, 8'h00);
        t_hold("R8 1.5 window ended", 6'b000100, 18, 1, 8'h1F);
        t_hold("R8 2 window still open", 6'b000111, 18, 0, 8'h00);
    endtask

    initial begin
        #700000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wait_ticks(4);
        t_lengths();
        t_odd_even();
        t_forced();
        t_framing();
        t_false_start();
        t_stop_lengths();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule